// File: doc/BRIEF.md
# Pointer-Addressed I2C Register Target

This block is an I2C target that sits in front of a 16-byte register file owned by a neighbouring block. It watches oversampled SCL and SDA. It never drives SDA high; it only pulls the line low through an open-drain enable. After its address byte, the host sends a command byte. The upper nibble of that byte picks a register, and the lower nibble picks how the rest of the transfer behaves: either a write burst or an immediate read. Reads can also begin after a repeated start. A read that has no command byte starts at register 15, because every stop parks the pointer there.

While a transfer is open, the block raises a hold flag so that time-keeping counters defer their carries until the stop. A slow tick input bounds how long a transfer may stay open. When that bound expires, the block drops the hold and parks the pointer. It then refuses writes and answers reads with all ones until the host sends a stop. When a transfer writes a one to the test bit of the control register, the block asks for that bit to be cleared when the stop arrives.

Top module: `regbus_target`

## Requirements
- R1: After a start, the block acknowledges an address byte whose upper seven bits equal 0110010 (0x64 to write, 0x65 to read). For any other address it leaves SDA released in the acknowledge slot.
- R2: The byte after a write address is taken as pointer (bits 7:4) and format (bits 3:0). Format 0x0 and format 0x4 are acknowledged. Any other format is not acknowledged, and the block then ignores the bus until the next start or stop.
- R3: In format 0x0, each further byte is written through rf_we at the pointer and acknowledged, and the pointer then advances by one. After 15 the pointer wraps to 0.
- R4: In format 0x4, the block starts sending right after the acknowledge of the command byte. The first byte is the pointed register.
- R5: During a read, the block sends the next register, with the pointer wrapping after 15, each time the host acknowledges. After a host NACK it keeps SDA released until a start or stop.
- R6: Every stop sets the pointer to 15. A read address with no preceding command byte therefore returns register 15 first.
- R7: A read address after a repeated start returns data from the pointer left by the preceding command byte.
- R8: hold_o rises after a start and stays high across repeated starts. It falls after the stop.
- R9: The timeout fires on the second tick_i pulse counted after the opening start, if no stop has come by then. At that point hold_o falls and the pointer becomes 15. Until the next stop, write addresses are not acknowledged, and read addresses are acknowledged but return 0xFF.
- R10: If a transfer writes a byte with bit 3 set to register 14, ctl_clear pulses for one cycle after its stop. Otherwise ctl_clear stays low.
- R11: sda_oe is high only in acknowledge slots and while the block sends a 0 data bit. Out of reset, sda_oe, hold_o and rf_we are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low |
| tick_i | input | 1 | Slow timeout tick, one pulse per half second |
| hold_o | output | 1 | Transfer open; defer counter carries |
| rf_addr | output | 4 | Register-file address (current pointer) |
| rf_wdata | output | 8 | Register-file write data |
| rf_we | output | 1 | Register-file write strobe |
| rf_rdata | input | 8 | Register-file read data at rf_addr |
| ctl_clear | output | 1 | One-cycle request to clear the test bit |

## Verification
An SCL or SDA change passes two synchroniser flops and one history flop before it is recognised. The registered reaction then lands on the third clock edge after the pad change, so sda_oe, hold_o and the pointer move three cycles after the bus event, and ctl_clear follows the stop edge by the same amount. The bench holds every SCL phase for ten clocks and samples SDA or sda_oe five clocks into the high phase, well after the reaction has settled. It checks hold_o and ctl_clear only once the whole start or stop phase has elapsed. The bench keeps its own expected register image and pointer, updated from the bytes it sends, and compares every byte it reads back against that image.

// File: rtl/rb_pkg.sv
package rb_pkg;
  localparam int PTR_W = 4;
  localparam logic [3:0] FMT_WRITE = 4'h0;
  localparam logic [3:0] FMT_FAST  = 4'h4;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_PTR, ST_PACK,
    ST_WDAT, ST_WACK, ST_RDAT, ST_RACK, ST_WAIT
  } rb_state_e;

  function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] dev);
    return b[7:1] == dev;
  endfunction

  function automatic logic fmt_ok(input logic [3:0] f);
    return (f == FMT_WRITE) || (f == FMT_FAST);
  endfunction
endpackage

// File: rtl/rb_line_sync.sv
module rb_line_sync #(
  parameter int STAGES = 2  // at least 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt,
  output logic sda_lvl
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;
  logic scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_q  <= scl_sh[STAGES-1];
      sda_q  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_lvl   = sda_sh[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_lvl;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/rb_guard.sv
module rb_guard #(
  parameter int TMO_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_evt,
  input  logic stop_evt,
  input  logic tick_i,
  output logic open_o,
  output logic lock_o,
  output logic tmo_evt
);
  localparam int CW = $clog2(TMO_TICKS + 1);
  logic [CW-1:0] tcnt;

  assign tmo_evt = open_o && tick_i && (tcnt == CW'(TMO_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_o <= 1'b0;
      lock_o <= 1'b0;
      tcnt   <= '0;
    end else if (stop_evt) begin
      open_o <= 1'b0;
      lock_o <= 1'b0;
      tcnt   <= '0;
    end else if (tmo_evt) begin
      open_o <= 1'b0;
      lock_o <= 1'b1;
      tcnt   <= '0;
    end else if (start_evt && !open_o && !lock_o) begin
      open_o <= 1'b1;
      tcnt   <= '0;
    end else if (open_o && tick_i) begin
      tcnt   <= tcnt + 1'b1;
    end
  end
endmodule

// File: rtl/rb_proto.sv
module rb_proto
  import rb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b0110010,
  parameter int         TEST_REG = 14,
  parameter int         TEST_BIT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic             sda_lvl,
  input  logic             tmo_evt,
  input  logic             lock_i,
  input  logic [7:0]       rf_rdata,
  output logic [PTR_W-1:0] rf_addr,
  output logic [7:0]       rf_wdata,
  output logic             rf_we,
  output logic             sda_oe,
  output logic             ctl_clear,
  output logic             ack_slot,
  output logic             tx_slot
);
  rb_state_e        state;
  logic [3:0]       cnt;
  logic [7:0]       sr, tx;
  logic [PTR_W-1:0] ptr;
  logic             rw, fast, go, test_seen;
  logic             byte_done;
  logic [7:0]       out_byte;

  assign byte_done = scl_fall && (cnt == 4'd8);
  assign out_byte  = lock_i ? 8'hFF : rf_rdata;
  assign rf_addr   = ptr;
  assign rf_wdata  = sr;
  assign rf_we     = (state == ST_WDAT) && byte_done && !stop_evt && !tmo_evt && !start_evt;
  assign ack_slot  = (state == ST_AACK) || (state == ST_PACK) || (state == ST_WACK);
  assign tx_slot   = (state == ST_RDAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; cnt <= '0; sr <= '0; tx <= '0; ptr <= '1;
      rw <= 1'b0; fast <= 1'b0; go <= 1'b0; test_seen <= 1'b0;
      sda_oe <= 1'b0; ctl_clear <= 1'b0;
    end else begin
      ctl_clear <= 1'b0;
      if (stop_evt) begin
        state <= ST_IDLE; sda_oe <= 1'b0; ptr <= '1;
        ctl_clear <= test_seen; test_seen <= 1'b0;
      end else if (tmo_evt) begin
        state <= ST_WAIT; sda_oe <= 1'b0; ptr <= '1;
      end else if (start_evt) begin
        state <= ST_ADDR; cnt <= '0; sda_oe <= 1'b0; go <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_PTR, ST_WDAT: begin
            if (scl_rise) begin
              sr  <= {sr[6:0], sda_lvl};
              cnt <= cnt + 4'd1;
            end else if (byte_done) begin
              cnt <= '0;
              if (state == ST_ADDR) begin
                if (addr_hit(sr, DEV_ADDR) && !(lock_i && !sr[0])) begin
                  rw <= sr[0]; sda_oe <= 1'b1; state <= ST_AACK;
                end else state <= ST_WAIT;
              end else if (state == ST_PTR) begin
                ptr  <= sr[7:4];
                fast <= (sr[3:0] == FMT_FAST);
                if (fmt_ok(sr[3:0])) begin
                  sda_oe <= 1'b1; state <= ST_PACK;
                end else state <= ST_WAIT;
              end else begin
                if (ptr == PTR_W'(TEST_REG) && sr[TEST_BIT]) test_seen <= 1'b1;
                ptr <= ptr + 1'b1; sda_oe <= 1'b1; state <= ST_WACK;
              end
            end
          end
          ST_AACK, ST_PACK, ST_WACK: begin
            if (scl_fall) begin
              if ((state == ST_AACK && rw) || (state == ST_PACK && fast)) begin
                tx <= out_byte; sda_oe <= ~out_byte[7]; cnt <= '0; state <= ST_RDAT;
              end else begin
                sda_oe <= 1'b0;
                state  <= (state == ST_AACK) ? ST_PTR : ST_WDAT;
              end
            end
          end
          ST_RDAT: begin
            if (scl_rise) cnt <= cnt + 4'd1;
            else if (byte_done) begin
              sda_oe <= 1'b0; cnt <= '0; state <= ST_RACK;
            end else if (scl_fall) begin
              tx <= {tx[6:0], 1'b0}; sda_oe <= ~tx[6];
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              if (sda_lvl) state <= ST_WAIT;
              else begin ptr <= ptr + 1'b1; go <= 1'b1; end
            end else if (scl_fall && go) begin
              go <= 1'b0; tx <= out_byte; sda_oe <= ~out_byte[7];
              cnt <= '0; state <= ST_RDAT;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/regbus_target.sv
module regbus_target
  import rb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b0110010,
  parameter int         SYNC_STAGES = 2,
  parameter int         TMO_TICKS   = 2,
  parameter int         TEST_REG    = 14,
  parameter int         TEST_BIT    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic             tick_i,
  output logic             hold_o,
  output logic [PTR_W-1:0] rf_addr,
  output logic [7:0]       rf_wdata,
  output logic             rf_we,
  input  logic [7:0]       rf_rdata,
  output logic             ctl_clear
);
  logic scl_rise, scl_fall, start_evt, stop_evt, sda_lvl;
  logic lock, tmo_evt, ack_slot, tx_slot;

  rb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .sda_lvl(sda_lvl)
  );

  rb_guard #(.TMO_TICKS(TMO_TICKS)) u_guard (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
    .tick_i(tick_i), .open_o(hold_o), .lock_o(lock), .tmo_evt(tmo_evt)
  );

  rb_proto #(.DEV_ADDR(DEV_ADDR), .TEST_REG(TEST_REG), .TEST_BIT(TEST_BIT)) u_proto (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .sda_lvl(sda_lvl),
    .tmo_evt(tmo_evt), .lock_i(lock), .rf_rdata(rf_rdata),
    .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_we(rf_we),
    .sda_oe(sda_oe), .ctl_clear(ctl_clear), .ack_slot(ack_slot), .tx_slot(tx_slot)
  );
endmodule

// File: rtl/regbus_target_chk.sv
module regbus_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic       hold_o,
  input logic [3:0] rf_addr,
  input logic       rf_we,
  input logic       ctl_clear,
  input logic       stop_evt,
  input logic       tmo_evt,
  input logic       ack_slot,
  input logic       tx_slot
);
  // R11
  oe_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (ack_slot || tx_slot));
  // R3
  we_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> (rf_addr == 4'($past(rf_addr) + 4'd1)));
  // R3
  we_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> hold_o);
  // R6
  stop_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (rf_addr == 4'hF));
  // R8
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !hold_o);
  // R9
  tmo_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |=> (!hold_o && rf_addr == 4'hF));
  // R10
  clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_clear |-> $past(stop_evt));
endmodule

bind regbus_target regbus_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .hold_o(hold_o),
  .rf_addr(rf_addr), .rf_we(rf_we), .ctl_clear(ctl_clear),
  .stop_evt(stop_evt), .tmo_evt(tmo_evt), .ack_slot(ack_slot), .tx_slot(tx_slot)
);

// File: tb/regbus_target_test.sv
`timescale 1ns/1ps
module regbus_target_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_drv = 1'b1, tick = 1'b0;
  logic sda_oe, hold_o, rf_we, ctl_clear;
  logic [3:0] rf_addr;
  logic [7:0] rf_wdata, rf_rdata;
  logic sda_line;
  logic [7:0] rf [16];
  logic [7:0] expm [16];
  int checks = 0, fails = 0, clr_cnt = 0, cyc = 0;

  always #10 clk = ~clk;  // 50 MHz

  assign sda_line = sda_drv & ~sda_oe;
  assign rf_rdata = rf[rf_addr];

  regbus_target uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .tick_i(tick), .hold_o(hold_o), .rf_addr(rf_addr), .rf_wdata(rf_wdata),
    .rf_we(rf_we), .rf_rdata(rf_rdata), .ctl_clear(ctl_clear)
  );

  initial for (int i = 0; i < 16; i++) begin
    rf[i] = 8'(i * 17) ^ 8'h5A;
    expm[i] = 8'(i * 17) ^ 8'h5A;
  end

  always @(posedge clk) begin
    if (rf_we) rf[rf_addr] <= rf_wdata;
    if (ctl_clear) begin rf[14][3] <= 1'b0; clr_cnt <= clr_cnt + 1; end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: act=hung exp=finished");
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, expv);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; scl = 1'b1; w(10); sda_drv = 1'b0; w(10); scl = 1'b0;
  endtask
  task automatic bus_rstart();
    w(2); sda_drv = 1'b1; w(8); scl = 1'b1; w(10); sda_drv = 1'b0; w(10); scl = 1'b0;
  endtask
  task automatic bus_stop();
    w(2); sda_drv = 1'b0; w(8); scl = 1'b1; w(10); sda_drv = 1'b1; w(10);
  endtask
  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      w(2); sda_drv = b[i]; w(8); scl = 1'b1; w(10); scl = 1'b0;
    end
    w(2); sda_drv = 1'b1; w(8); scl = 1'b1; w(5); ack = sda_oe; w(5); scl = 1'b0;
  endtask
  task automatic recv_byte(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      w(10); scl = 1'b1; w(5); b[i] = sda_line; w(5); scl = 1'b0;
    end
    w(2); sda_drv = mack ? 1'b0 : 1'b1; w(8); scl = 1'b1; w(10); scl = 1'b0;
    w(2); sda_drv = 1'b1;
  endtask

  logic a;
  logic [7:0] d;

  initial begin
    w(3);
    chk("R11 reset oe", sda_oe, 0);
    chk("R11 reset hold", hold_o, 0);
    chk("R11 reset we", rf_we, 0);
    rst_n = 1'b1; w(5);

    // write burst E,F,0
    bus_start();
    chk("R8 hold after start", hold_o, 1);
    send_byte(8'h64, a); chk("R1 write address ack", a, 1);
    send_byte(8'hE0, a); chk("R2 format 0 ack", a, 1);
    send_byte(8'hA1, a); chk("R3 data ack E", a, 1); expm[14] = 8'hA1;
    send_byte(8'hB2, a); chk("R3 data ack F", a, 1); expm[15] = 8'hB2;
    send_byte(8'hC3, a); chk("R3 data ack wrap", a, 1); expm[0] = 8'hC3;
    bus_stop();
    chk("R8 hold after stop", hold_o, 0);
    chk("R3 stored E", rf[14], expm[14]);
    chk("R3 stored 0 after wrap", rf[0], expm[0]);
    chk("R10 no clear without test bit", clr_cnt, 0);

    // wrong address
    bus_start();
    send_byte(8'h66, a); chk("R1 foreign address nack", a, 0);
    bus_stop();

    // read after repeated start
    bus_start();
    send_byte(8'h64, a);
    send_byte(8'h20, a); chk("R2 pointer byte ack", a, 1);
    bus_rstart();
    chk("R8 hold across repeated start", hold_o, 1);
    send_byte(8'h65, a); chk("R1 read address ack", a, 1);
    recv_byte(1'b1, d); chk("R7 read reg 2", d, expm[2]);
    recv_byte(1'b0, d); chk("R5 read continues reg 3", d, expm[3]);
    bus_stop();

    // fast read with wrap
    bus_start();
    send_byte(8'h64, a);
    send_byte(8'hE4, a); chk("R2 format 4 ack", a, 1);
    recv_byte(1'b1, d); chk("R4 fast read E", d, expm[14]);
    recv_byte(1'b1, d); chk("R5 fast read F", d, expm[15]);
    recv_byte(1'b0, d); chk("R5 read wraps to 0", d, expm[0]);
    bus_stop();

    // default read from F
    bus_start();
    send_byte(8'h65, a); chk("R1 read address ack", a, 1);
    recv_byte(1'b0, d); chk("R6 default read reg F", d, expm[15]);
    bus_stop();

    // bad format
    bus_start();
    send_byte(8'h64, a);
    send_byte(8'h21, a); chk("R2 bad format nack", a, 0);
    bus_stop();

    // nack ends read
    bus_start();
    send_byte(8'h65, a);
    recv_byte(1'b0, d); chk("R6 read starts at F", d, expm[15]);
    recv_byte(1'b0, d); chk("R5 released after nack", d, 8'hFF);
    bus_stop();

    // test bit
    bus_start();
    send_byte(8'h64, a);
    send_byte(8'hE0, a);
    send_byte(8'h0C, a); chk("R3 data ack test reg", a, 1);
    chk("R10 no clear before stop", clr_cnt, 0);
    bus_stop();
    expm[14] = 8'h04;
    chk("R10 clear pulse after stop", clr_cnt, 1);
    bus_start();
    send_byte(8'h64, a);
    send_byte(8'hE4, a);
    recv_byte(1'b0, d); chk("R10 test bit cleared", d, expm[14]);
    bus_stop();

    // timeout
    bus_start();
    send_byte(8'h64, a); chk("R1 ack before timeout", a, 1);
    chk("R9 hold open", hold_o, 1);
    @(negedge clk) tick = 1'b1; @(negedge clk) tick = 1'b0;
    w(3); chk("R9 hold after one tick", hold_o, 1);
    @(negedge clk) tick = 1'b1; @(negedge clk) tick = 1'b0;
    w(3); chk("R9 hold released", hold_o, 0);
    bus_rstart();
    send_byte(8'h64, a); chk("R9 write refused", a, 0);
    bus_rstart();
    chk("R9 hold stays low", hold_o, 0);
    send_byte(8'h65, a); chk("R9 read address ack", a, 1);
    recv_byte(1'b0, d); chk("R9 locked read FF", d, 8'hFF);
    bus_stop();
    bus_start();
    send_byte(8'h65, a); chk("R9 ack after stop", a, 1);
    recv_byte(1'b0, d); chk("R6 read F after timeout", d, expm[15]);
    bus_stop();

    summary();
    $finish;
  end
endmodule